// File: doc/BRIEF.md
# Modulator Clock and Sync Phase-Reset Generator

This block derives the modulator clock from the system clock and turns an asynchronous, rising-edge sync request into a retimed pulse that is aligned to that clock. The request passes through a two-flop synchronizer. It is caught on a modulator clock rising edge and launched on the following falling edge. At that launch point the block restarts its output-period (decimation) counter. It also optionally resets the test-stream data pointer, and drives the retimed pulse to the modulator sync pin when that pin is enabled.

The output-period counter advances once per modulator clock falling edge and raises a word strobe every `dec_cnt_i` falling edges. After a sync, the next strobe comes one full output period later. When syncs repeat exactly at the output rate, each one lands on a period boundary. It is then absorbed, and the strobe cadence does not change.

All logic runs on the system clock. The modulator clock edges are produced as one-cycle tick strobes in the cycle before `mclk_o` toggles.

Top module: `msync_gen`

## Requirements
- R1: `mclk_o` has a period of 2^(`div_sel_i`+1) system clocks with equal high and low halves. After reset it starts low and makes its first rising transition before its first falling one.
- R2: `sync_i` is edge triggered. A level held high across many modulator periods produces exactly one sync event, and the event needs a new low-to-high transition to repeat.
- R3: A synchronized rising edge of `sync_i` is captured at the next modulator clock rising tick. It is then launched at the falling tick after that capture. `phase_rst_o` is a one-system-clock pulse in the last cycle before `mclk_o` falls, at that launch.
- R4: When `msync_en_i` is 1, `msync_o` goes high at the launch falling edge and stays high for one modulator clock period. When `msync_en_i` is 0, `msync_o` stays low.
- R5: `word_stb_o` is a one-system-clock pulse in the last cycle before `mclk_o` falls, on every `dec_cnt_i`-th falling edge. The first pulse comes at the `dec_cnt_i`-th falling edge after reset.
- R6: After a sync launch that is not on a period boundary, no strobe comes until exactly `dec_cnt_i` falling edges after the launch edge. Strobes then continue every `dec_cnt_i` edges.
- R7: A sync launched on the falling edge that carries a strobe leaves that strobe and all later strobe timing unchanged.
- R8: `tbs_rst_o` pulses together with `phase_rst_o` when `tsync_en_i` is 1, and stays low when `tsync_en_i` is 0.
- R9: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Asynchronous sync request, rising edge |
| msync_en_i | input | 1 | Drive the retimed sync to `msync_o` |
| tsync_en_i | input | 1 | Let sync reset the test-stream pointer |
| div_sel_i | input | DIV_SEL_W | Modulator clock divide select, divide by 2^(n+1) |
| dec_cnt_i | input | CNT_W | Output period in modulator clock periods |
| mclk_o | output | 1 | Modulator clock |
| msync_o | output | 1 | Retimed sync pin, one modulator period wide |
| phase_rst_o | output | 1 | Decimation phase restart pulse |
| word_stb_o | output | 1 | Output word strobe |
| tbs_rst_o | output | 1 | Test-stream pointer reset pulse |

## Verification
Suppose the pending or armed capture state were wrong. The launch would then move by a whole modulator period, or a held sync level would retrigger. Either shows at the first falling edge after the expected launch, as an extra or missing `phase_rst_o`. A corrupted phase count moves every later `word_stb_o`, so the error appears within one output period and never heals by itself. Boundary-aligned syncs are driven to show that an absorbed restart leaves the strobe sequence unchanged.

// File: rtl/msync_pkg.sv
package msync_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } mclk_tick_t;
endpackage

// File: rtl/msync_clkdiv.sv
module msync_clkdiv
  import msync_pkg::*;
#(
  parameter int DIV_SEL_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 mclk_o,
  output mclk_tick_t           tick_o
);
  localparam int PRE_W = 1 << DIV_SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] half_m1;
  logic [PRE_W-1:0] full_m1;
  logic             mclk_q;

  assign half_m1 = (PRE_W'(1) << div_sel_i) - PRE_W'(1);
  assign full_m1 = (PRE_W'(2) << div_sel_i) - PRE_W'(1);

  // fall only when the clock is actually high, so the first edge after reset is a rise
  assign tick_o.rise = (pre_q == full_m1);
  assign tick_o.fall = (pre_q == half_m1) && mclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      pre_q <= tick_o.rise ? '0 : pre_q + PRE_W'(1);
      if (tick_o.rise)      mclk_q <= 1'b1;
      else if (tick_o.fall) mclk_q <= 1'b0;
    end
  end

  assign mclk_o = mclk_q;

  p_rise_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o.rise |=> mclk_o);
  p_fall_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o.fall |=> !mclk_o);
endmodule

// File: rtl/msync_capture.sv
module msync_capture
  import msync_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  mclk_tick_t tick_i,
  output logic       fire_o,
  output logic       msync_o
);
  logic [2:0] sync_q;
  logic       sync_edge;
  logic       pend_q;
  logic       armed_q;
  logic       msync_q;

  // [0],[1]: synchronizer, [2]: history for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], sync_i};
  end

  assign sync_edge = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      msync_q <= 1'b0;
    end else begin
      if (tick_i.rise)    pend_q <= 1'b0;
      else if (sync_edge) pend_q <= 1'b1;

      if (tick_i.rise)      armed_q <= pend_q || sync_edge;
      else if (tick_i.fall) armed_q <= 1'b0;

      if (tick_i.fall) msync_q <= armed_q;
    end
  end

  assign fire_o  = tick_i.fall && armed_q;
  assign msync_o = msync_q;

  p_capture_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(tick_i.rise));
  p_launch_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msync_q) |-> $past(tick_i.fall));
endmodule

// File: rtl/msync_phase.sv
module msync_phase #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] dec_cnt_i,
  output logic             word_stb_o
);
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] lim;
  logic             last;

  assign lim  = (dec_cnt_i == '0) ? '0 : dec_cnt_i - CNT_W'(1);
  assign last = (phase_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         phase_q <= '0;
    else if (fall_i && (last || fire_i)) phase_q <= '0;
    else if (fall_i)                     phase_q <= phase_q + CNT_W'(1);
  end

  // boundary sync: strobe kept, wrap identical to free run
  assign word_stb_o = fall_i && last;

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && fire_i) |=> (phase_q == '0));
  p_stb_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |=> (phase_q == '0));
endmodule

// File: rtl/msync_gen.sv
module msync_gen
  import msync_pkg::*;
#(
  parameter int DIV_SEL_W = 3,
  parameter int CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic                 msync_en_i,
  input  logic                 tsync_en_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [CNT_W-1:0]     dec_cnt_i,
  output logic                 mclk_o,
  output logic                 msync_o,
  output logic                 phase_rst_o,
  output logic                 word_stb_o,
  output logic                 tbs_rst_o
);
  mclk_tick_t tick;
  logic       fire;
  logic       msync_raw;

  msync_clkdiv #(.DIV_SEL_W(DIV_SEL_W)) u_clkdiv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_sel_i (div_sel_i),
    .mclk_o    (mclk_o),
    .tick_o    (tick)
  );

  msync_capture u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .tick_i  (tick),
    .fire_o  (fire),
    .msync_o (msync_raw)
  );

  msync_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (tick.fall),
    .fire_i     (fire),
    .dec_cnt_i  (dec_cnt_i),
    .word_stb_o (word_stb_o)
  );

  assign phase_rst_o = fire;
  assign msync_o     = msync_raw && msync_en_i;
  assign tbs_rst_o   = fire && tsync_en_i;

  p_stb_mclk_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> mclk_o);
  p_fire_mclk_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_rst_o |-> mclk_o);
  p_fire_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_rst_o |=> msync_raw);
endmodule

// File: tb/msync_gen_tb.sv
module msync_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic       msync_en_i = 1'b0;
  logic       tsync_en_i = 1'b0;
  logic [2:0] div_sel_i = 3'd1;
  logic [7:0] dec_cnt_i = 8'd5;
  logic       mclk_o, msync_o, phase_rst_o, word_stb_o, tbs_rst_o;

  msync_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .msync_en_i(msync_en_i), .tsync_en_i(tsync_en_i),
    .div_sel_i(div_sel_i), .dec_cnt_i(dec_cnt_i),
    .mclk_o(mclk_o), .msync_o(msync_o), .phase_rst_o(phase_rst_o),
    .word_stb_o(word_stb_o), .tbs_rst_o(tbs_rst_o)
  );

  always #10 clk_i = ~clk_i;

  int    errors = 0;
  int    checks = 0;
  int    tick_cnt = 0;
  int    cyc = 0;
  int    last_fall_cyc = -1;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R5";
  int    q_stb[$];
  int    q_fire[$];
  int    q_tbs[$];
  int    q_ms[$];
  logic  p_mclk, p_ms, p_stb, p_fire, p_tbs;
  event  tick_ev;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s tick=%0d actual=%0d expected=%0d", req, tick_cnt, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc++;

  // monitor: a falling mclk_o between samples marks a tick in the previous sample
  always @(negedge clk_i) begin
    if (!mon_on) begin
      p_mclk = 1'b0;
    end else begin
      if (p_mclk && !mclk_o) begin
        bit e;
        tick_cnt++;
        e = (q_stb.size() > 0 && q_stb[0] == tick_cnt);
        if (e) void'(q_stb.pop_front());
        check({tag, " word_stb"}, int'(p_stb), int'(e));
        e = (q_fire.size() > 0 && q_fire[0] == tick_cnt);
        if (e) void'(q_fire.pop_front());
        check({tag, " phase_rst"}, int'(p_fire), int'(e));
        e = (q_tbs.size() > 0 && q_tbs[0] == tick_cnt);
        if (e) void'(q_tbs.pop_front());
        check("R8 tbs_rst", int'(p_tbs), int'(e));
        e = (q_ms.size() > 0 && q_ms[0] == tick_cnt);
        if (e) void'(q_ms.pop_front());
        check("R4 msync", int'(p_ms), int'(e));
        if (last_fall_cyc >= 0)
          check("R1 mclk period", cyc - last_fall_cyc, 2 << div_sel_i);
        last_fall_cyc = cyc;
        ->tick_ev;
      end
      p_mclk = mclk_o;
    end
    p_ms   = msync_o;
    p_stb  = word_stb_o;
    p_fire = phase_rst_o;
    p_tbs  = tbs_rst_o;
  end

  task automatic do_reset(input logic [2:0] sel, input logic [7:0] n);
    @(negedge clk_i);
    rst_ni = 1'b0;
    mon_on = 1'b0;
    q_stb.delete(); q_fire.delete(); q_tbs.delete(); q_ms.delete();
    div_sel_i = sel;
    dec_cnt_i = n;
    repeat (3) @(negedge clk_i);
    check("R9 reset mclk", int'(mclk_o), 0);
    check("R9 reset outs", int'({msync_o, phase_rst_o, word_stb_o, tbs_rst_o}), 0);
    rst_ni = 1'b1;
    tick_cnt = 0;
    last_fall_cyc = -1;
    mon_on = 1'b1;
  endtask

  task automatic wait_until(input int t);
    while (tick_cnt < t) @(tick_ev);
  endtask

  // drives a sync right after the next tick; dl = ticks from that tick to the launch
  task automatic do_sync(input int dl, input int nstb, input int hold,
                         input bit en, input bit ts);
    int f;
    msync_en_i = en;
    tsync_en_i = ts;
    @(tick_ev);
    f = tick_cnt + dl;
    sync_i = 1'b1;
    q_fire.push_back(f);
    if (ts) q_tbs.push_back(f);
    if (en) q_ms.push_back(f + 1);
    for (int k = 1; k <= nstb; k++) begin
      int v;
      v = f + int'(dec_cnt_i) * k;
      if (q_stb.size() == 0 || q_stb[$] < v) q_stb.push_back(v);
    end
    repeat (hold) @(negedge clk_i);
    sync_i = 1'b0;
  endtask

  task automatic drained(input string req);
    check({req, " pending expectations"},
          q_stb.size() + q_fire.size() + q_tbs.size() + q_ms.size(), 0);
  endtask

  initial begin
    // phase A: divide by 4, output period 5
    do_reset(3'd1, 8'd5);
    tag = "R5";
    q_stb.push_back(5); q_stb.push_back(10); q_stb.push_back(15);
    wait_until(15);
    tag = "R2";
    do_sync(2, 3, 60, 1'b1, 1'b1);      // drive at 16, launch 18, held high
    wait_until(33);
    tag = "R6";
    do_sync(2, 2, 8, 1'b0, 1'b0);       // drive at 34, launch 36, pin and pointer gated off
    wait_until(43);
    tag = "R7";
    do_sync(2, 2, 4, 1'b1, 1'b0);       // launch 46, equals strobe boundary
    wait_until(48);
    do_sync(2, 2, 4, 1'b1, 1'b0);       // launch 51, repeated at output rate
    wait_until(62);
    drained("R7");

    // phase B: divide by 8, output period 3
    do_reset(3'd2, 8'd3);
    tag = "R5";
    q_stb.push_back(3); q_stb.push_back(6); q_stb.push_back(9);
    wait_until(9);
    tag = "R3";
    do_sync(1, 2, 6, 1'b1, 1'b1);       // drive at 10, launch 11
    wait_until(18);
    drained("R3");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog tick=%0d actual=hung expected=done", tick_cnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule